// File: doc/BRIEF.md
# Interrupt Status and Mask Controller

This block gathers single-cycle event pulses from a set of interrupt sources and holds them in a status word. A host finds the cause of an interrupt by reading that word. Two of its bits are summaries. The extended summary reflects a separate extended status register. The command-change summary reflects a latched command code. Each summary bit is cleared only by reading its own register, so a read of the main status word leaves it alone.

A write-only mask shares the address of the status word. A set mask bit stops its source from reaching the interrupt pin, but the status bit is still recorded. The single active-low pin `irq_no` is updated only when the sampled data clock rises. After any clearing read, the pin is forced inactive at the next data-clock rise. It is then re-evaluated at the rise after that, so the pin shows a fresh falling edge whenever work is still pending.

Top module: `intc_ctrl`

## Requirements
- R1: The status word at address 0 is 9 bits wide. Bits 6:0 are the sources `src_evt_i[6:0]`, bit 7 is the extended summary and bit 8 is the command-change summary. A pulse on a source sets its bit until that bit is cleared.
- R2: A write at address 0 loads the mask from `wdata_i[8:0]`. A mask bit of 1 keeps the matching status bit off the interrupt pin, but the status bit is still set and still reads back.
- R3: A read at address 0 returns the status word. It then clears bits 6:0 and leaves bits 8:7 unchanged.
- R4: A pulse on `cmd_chg_i` latches `cmd_code_i` and sets status bit 8. A read at address 2 returns the code in bits 3:0 and clears bit 8.
- R5: An extended event sets its bit in the extended register, and status bit 7 is the OR of that register. A read at address 1 returns the register in bits 7:0 and clears it, which also clears bit 7.
- R6: `irq_no` changes only in the clock cycle in which a rising edge of `dclk_i` is detected.
- R7: At a data-clock rise with no clearing read pending, `irq_no` becomes 0 if any unmasked status bit is set and 1 otherwise.
- R8: A read at address 0, 1 or 2 forces `irq_no` to 1 at the next data-clock rise. The following rise applies R7 again.
- R9: An event that arrives in the same cycle as a read that clears its bit is kept.
- R10: After reset, all status, extended and command flags are clear, the mask is 0 and `irq_no` is 1.
- R11: A read at address 3 returns 0, clears nothing and does not force the pin inactive.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| dclk_i | input | 1 | Data clock, sampled by clk_i |
| src_evt_i | input | 7 | Per-source event pulses |
| ext_evt_i | input | 8 | Extended event pulses |
| cmd_chg_i | input | 1 | Command-code change pulse |
| cmd_code_i | input | 4 | Command code latched on change |
| rd_en_i | input | 1 | Read strobe (clears on the edge) |
| wr_en_i | input | 1 | Write strobe |
| addr_i | input | 2 | Register select |
| wdata_i | input | 9 | Write data (mask) |
| rdata_o | output | 9 | Read data for addr_i |
| irq_no | output | 1 | Active-low interrupt request |

## Verification
A table of source patterns is applied with different masks: a single low source, a masked top source, mixed patterns where only some bits are unmasked, an empty pattern, and all sources with everything masked. Together these show whether the pin follows only the unmasked bits while the readback stays unmasked. Directed sequences then separate the three clearing paths. Repeated status reads must leave both summary bits set, and only their own reads clear them. Events are placed in the same cycle as a clearing read to show that they are kept. The pin is traced over consecutive data-clock rises to expose the forced inactive period and the re-assertion that follows it.

// File: rtl/intc_pkg.sv
package intc_pkg;
  typedef enum logic [1:0] {
    SEL_STS  = 2'd0,
    SEL_EXT  = 2'd1,
    SEL_CMD  = 2'd2,
    SEL_NONE = 2'd3
  } reg_sel_e;
endpackage

// File: rtl/intc_src_bank.sv
module intc_src_bank #(
  parameter int NSRC = 7
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic [NSRC-1:0] evt_i,
  input  logic            clr_i,
  output logic [NSRC-1:0] sts_o
);
  for (genvar i = 0; i < NSRC; i++) begin : g_bit
    logic bit_q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) bit_q <= 1'b0;
      else         bit_q <= (bit_q & ~clr_i) | evt_i[i];
    end
    assign sts_o[i] = bit_q;
  end
endmodule

// File: rtl/intc_ext_bank.sv
module intc_ext_bank #(
  parameter int NEXT = 8
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic [NEXT-1:0] evt_i,
  input  logic            clr_i,
  output logic [NEXT-1:0] ext_o,
  output logic            any_o
);
  logic [NEXT-1:0] ext_q;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) ext_q <= '0;
    else         ext_q <= (clr_i ? '0 : ext_q) | evt_i;
  end
  assign ext_o = ext_q;
  assign any_o = |ext_q;
endmodule

// File: rtl/intc_cmd_latch.sv
module intc_cmd_latch #(
  parameter int CIW = 4
) (
  input  logic           clk_i,
  input  logic           rst_ni,
  input  logic           chg_i,
  input  logic [CIW-1:0] code_i,
  input  logic           clr_i,
  output logic [CIW-1:0] code_o,
  output logic           flag_o
);
  logic [CIW-1:0] code_q;
  logic           flag_q;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      code_q <= '0;
      flag_q <= 1'b0;
    end else begin
      if (chg_i) code_q <= code_i;
      flag_q <= (flag_q & ~clr_i) | chg_i;
    end
  end
  assign code_o = code_q;
  assign flag_o = flag_q;
endmodule

// File: rtl/intc_pin_gen.sv
module intc_pin_gen (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic dclk_i,
  input  logic pend_i,
  input  logic blank_req_i,
  output logic irq_no
);
  logic dclk_q, blank_q, irq_q;
  logic rise, blank_eff;

  assign rise      = dclk_i & ~dclk_q;
  assign blank_eff = blank_q | blank_req_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      dclk_q  <= 1'b0;
      blank_q <= 1'b0;
      irq_q   <= 1'b1;
    end else begin
      dclk_q <= dclk_i;
      if (rise) begin
        irq_q   <= blank_eff | ~pend_i;
        blank_q <= 1'b0;
      end else begin
        blank_q <= blank_eff;
      end
    end
  end
  assign irq_no = irq_q;
endmodule

// File: rtl/intc_ctrl.sv
module intc_ctrl
  import intc_pkg::*;
#(
  parameter int NSRC = 7,
  parameter int NEXT = 8,
  parameter int CIW  = 4,
  localparam int DW  = NSRC + 2
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            dclk_i,
  input  logic [NSRC-1:0] src_evt_i,
  input  logic [NEXT-1:0] ext_evt_i,
  input  logic            cmd_chg_i,
  input  logic [CIW-1:0]  cmd_code_i,
  input  logic            rd_en_i,
  input  logic            wr_en_i,
  input  logic [1:0]      addr_i,
  input  logic [DW-1:0]   wdata_i,
  output logic [DW-1:0]   rdata_o,
  output logic            irq_no
);
  logic            rd_sts, rd_ext, rd_cmd;
  logic [NSRC-1:0] src_sts;
  logic [NEXT-1:0] ext_q;
  logic            ext_any, cmd_flag;
  logic [CIW-1:0]  cmd_code;
  logic [DW-1:0]   mask_q, sts_word;
  logic            pend;

  assign rd_sts = rd_en_i && (addr_i == SEL_STS);
  assign rd_ext = rd_en_i && (addr_i == SEL_EXT);
  assign rd_cmd = rd_en_i && (addr_i == SEL_CMD);

  intc_src_bank #(.NSRC(NSRC)) u_src (
    .clk_i, .rst_ni, .evt_i(src_evt_i), .clr_i(rd_sts), .sts_o(src_sts)
  );

  intc_ext_bank #(.NEXT(NEXT)) u_ext (
    .clk_i, .rst_ni, .evt_i(ext_evt_i), .clr_i(rd_ext), .ext_o(ext_q), .any_o(ext_any)
  );

  intc_cmd_latch #(.CIW(CIW)) u_cmd (
    .clk_i, .rst_ni, .chg_i(cmd_chg_i), .code_i(cmd_code_i), .clr_i(rd_cmd),
    .code_o(cmd_code), .flag_o(cmd_flag)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                             mask_q <= '0;
    else if (wr_en_i && addr_i == SEL_STS)   mask_q <= wdata_i;
  end

  assign sts_word = {cmd_flag, ext_any, src_sts};
  assign pend     = |(sts_word & ~mask_q);

  always_comb begin
    rdata_o = '0;
    case (addr_i)
      SEL_STS: rdata_o = sts_word;
      SEL_EXT: rdata_o[NEXT-1:0] = ext_q;
      SEL_CMD: rdata_o[CIW-1:0]  = cmd_code;
      default: rdata_o = '0;
    endcase
  end

  intc_pin_gen u_pin (
    .clk_i, .rst_ni, .dclk_i, .pend_i(pend),
    .blank_req_i(rd_sts | rd_ext | rd_cmd), .irq_no
  );
endmodule

// File: rtl/intc_ctrl_chk.sv
module intc_ctrl_chk #(
  parameter int NSRC = 7,
  parameter int NEXT = 8
) (
  input logic            clk_i,
  input logic            rst_ni,
  input logic            dclk_i,
  input logic            rd_en_i,
  input logic [1:0]      addr_i,
  input logic [NSRC-1:0] src_evt_i,
  input logic [NEXT-1:0] ext_evt_i,
  input logic            cmd_chg_i,
  input logic            irq_no,
  input logic [NSRC-1:0] src_sts,
  input logic [NEXT-1:0] ext_q,
  input logic            cmd_flag
);
  logic dclk_q, rise;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) dclk_q <= 1'b0;
    else         dclk_q <= dclk_i;
  end
  assign rise = dclk_i & ~dclk_q;

  AST_PIN_ON_DCLK: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !rise |=> $stable(irq_no)); // R6
  AST_STS_CLEAR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_en_i && addr_i == 2'd0 && src_evt_i == '0) |=> (src_sts == '0)); // R3
  AST_CMD_KEPT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_en_i && addr_i == 2'd0 && cmd_flag) |=> cmd_flag); // R3
  AST_CMD_CLEAR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_en_i && addr_i == 2'd2 && !cmd_chg_i) |=> !cmd_flag); // R4
  AST_EXT_CLEAR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_en_i && addr_i == 2'd1 && ext_evt_i == '0) |=> (ext_q == '0)); // R5
  AST_EVT_KEPT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (src_evt_i != '0) |=> ((src_sts & $past(src_evt_i)) == $past(src_evt_i))); // R9
  AST_BLANK_ON_READ: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_en_i && addr_i != 2'd3 && rise) |=> irq_no); // R8
endmodule

bind intc_ctrl intc_ctrl_chk #(.NSRC(NSRC), .NEXT(NEXT)) u_chk (.*);

// File: tb/intc_ctrl_test.sv
module intc_ctrl_test;
  logic       clk = 1'b0, rst_n = 1'b0, dclk = 1'b0;
  logic [6:0] src = '0;
  logic [7:0] ext = '0;
  logic       chg = 1'b0, rd = 1'b0, wr = 1'b0;
  logic [3:0] code = '0;
  logic [1:0] addr = '0;
  logic [8:0] wdata = '0, rdata;
  logic       irq_n;
  int n_run = 0, n_fail = 0;
  bit done = 0;

  intc_ctrl uut (
    .clk_i(clk), .rst_ni(rst_n), .dclk_i(dclk), .src_evt_i(src), .ext_evt_i(ext),
    .cmd_chg_i(chg), .cmd_code_i(code), .rd_en_i(rd), .wr_en_i(wr), .addr_i(addr),
    .wdata_i(wdata), .rdata_o(rdata), .irq_no(irq_n)
  );

  always #2 clk = ~clk;

  initial begin
    forever begin
      repeat (4) @(posedge clk);
      #1 dclk = ~dclk;
    end
  end

  typedef struct packed {
    logic [6:0] src;
    logic [8:0] mask;
    logic       exp_irq_n;
  } vec_t;

  localparam vec_t VECS [6] = '{
    '{7'b0000001, 9'h000, 1'b0},
    '{7'b1000000, 9'h040, 1'b1},
    '{7'b1010101, 9'h005, 1'b0},
    '{7'b0000000, 9'h000, 1'b1},
    '{7'b1111111, 9'h07F, 1'b1},
    '{7'b0100000, 9'h01F, 1'b0}
  };

  task automatic chk(input string req, input logic [8:0] got, input logic [8:0] exp);
    n_run++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s: got %0h expected %0h", req, got, exp);
    end
  endtask

  task automatic tick;
    @(posedge clk); #1;
  endtask

  task automatic rd_reg(input logic [1:0] a, output logic [8:0] d);
    rd = 1'b1; addr = a;
    @(negedge clk); d = rdata;
    tick;
    rd = 1'b0; addr = '0;
  endtask

  task automatic wr_mask(input logic [8:0] m);
    wr = 1'b1; addr = '0; wdata = m;
    tick;
    wr = 1'b0;
  endtask

  task automatic pulse_src(input logic [6:0] s);
    src = s; tick; src = '0;
  endtask

  task automatic pulse_ext(input logic [7:0] e);
    ext = e; tick; ext = '0;
  endtask

  task automatic dclk_rise(output logic p);
    @(posedge dclk);
    @(posedge clk);
    @(negedge clk); p = irq_n;
    tick;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    logic [8:0] d;
    logic       p;
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    tick;
    // R10 reset state
    chk("R10 irq", {8'h0, irq_n}, 9'h1);
    rd_reg(2'd0, d); chk("R10 status", d, 9'h000);
    dclk_rise(p); dclk_rise(p);

    // R1 R2 R3 R7 table
    foreach (VECS[i]) begin
      wr_mask(VECS[i].mask);
      pulse_src(VECS[i].src);
      dclk_rise(p); chk("R7 R2 vector irq", {8'h0, p}, {8'h0, VECS[i].exp_irq_n});
      rd_reg(2'd0, d); chk("R1 R3 vector status", d, {2'b00, VECS[i].src});
      dclk_rise(p); dclk_rise(p);
    end
    wr_mask(9'h000);

    // R6 pin holds until next data-clock rise
    dclk_rise(p);
    pulse_src(7'b0001000);
    @(negedge clk); chk("R6 no change before rise", {8'h0, irq_n}, 9'h1);
    tick;
    dclk_rise(p); chk("R7 asserted at rise", {8'h0, p}, 9'h0);

    // R8 R9 clearing read with simultaneous event
    rd = 1'b1; addr = 2'd0; src = 7'b0000010;
    @(negedge clk); d = rdata;
    tick;
    rd = 1'b0; src = '0;
    chk("R3 read value", d, 9'h008);
    dclk_rise(p); chk("R8 blanked", {8'h0, p}, 9'h1);
    dclk_rise(p); chk("R8 reasserted", {8'h0, p}, 9'h0);
    rd_reg(2'd0, d); chk("R9 event kept", d, 9'h002);
    dclk_rise(p); dclk_rise(p); chk("R7 idle high", {8'h0, p}, 9'h1);

    // R5 extended register
    pulse_ext(8'h08);
    rd_reg(2'd0, d); chk("R5 ext summary", d, 9'h080);
    rd_reg(2'd0, d); chk("R3 ext summary kept", d, 9'h080);
    rd_reg(2'd1, d); chk("R5 ext read", d, 9'h008);
    rd_reg(2'd0, d); chk("R5 ext summary cleared", d, 9'h000);
    pulse_ext(8'h01);
    ext = 8'h02; rd = 1'b1; addr = 2'd1;
    @(negedge clk); d = rdata;
    tick;
    ext = '0; rd = 1'b0; addr = '0;
    chk("R5 ext read value", d, 9'h001);
    rd_reg(2'd1, d); chk("R9 ext event kept", d, 9'h002);

    // R4 command change
    code = 4'hA; chg = 1'b1; tick; chg = 1'b0; code = 4'h3;
    rd_reg(2'd0, d); chk("R4 cmd summary", d, 9'h100);
    rd_reg(2'd0, d); chk("R3 cmd summary kept", d, 9'h100);
    rd_reg(2'd2, d); chk("R4 cmd code", d, 9'h00A);
    rd_reg(2'd0, d); chk("R4 cmd summary cleared", d, 9'h000);

    // R2 masked summary bit still recorded
    wr_mask(9'h080);
    pulse_ext(8'h10);
    dclk_rise(p); dclk_rise(p); chk("R2 masked no irq", {8'h0, p}, 9'h1);
    rd_reg(2'd0, d); chk("R2 masked bit visible", d, 9'h080);
    rd_reg(2'd1, d);
    wr_mask(9'h000);
    dclk_rise(p); dclk_rise(p);

    // R11 unused address
    pulse_src(7'b0000100);
    rd_reg(2'd3, d); chk("R11 zero read", d, 9'h000);
    dclk_rise(p); chk("R11 no blanking", {8'h0, p}, 9'h0);
    rd_reg(2'd0, d); chk("R11 nothing cleared", d, 9'h004);

    done = 1;
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule